// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of a network controller. Host software owns a ring of 16-byte descriptors in memory. Each descriptor holds a control word, a tag word, and a 64-bit buffer pointer split into a low and a high word. Software hands a descriptor to the device by setting its ownership bit and putting the buffer size in the low control bits. When a frame arrives on the byte stream, the block reads the descriptor at its current index. It writes the frame bytes into that buffer and then writes the control word back with the length, the segment flags and the status. Ownership returns to the host in that same write.

A frame that does not fit in one buffer continues in the following descriptors. The first piece is flagged as first and the final piece as last. The ring has no fixed size: a descriptor with the end-of-ring bit sends the index back to the ring base. When no descriptor is available, the block raises a pulse and either drops the frame or truncates it. The memory is a single port with byte enables and a fixed read latency of one cycle. Only the low 32 bits of the buffer pointer are used.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the block does not accept stream bytes, issues no memory request, holds the missed-frame count at zero and raises no interrupt pulse.
- R2: When the first byte of a frame is presented, the block reads the control word at offset 0 of the current descriptor. If bit 31 (ownership) is set, it takes the buffer size from bits [12:0] and then reads the buffer address from offset 8.
- R3: Frame bytes are written one per cycle to consecutive buffer addresses. Each is a single-byte write whose enable bit equals the address modulo 4, with the byte copied on all four lanes. No more bytes are accepted than the buffer size.
- R4: Each writeback is a full-word write to offset 0 of the descriptor, made after all data writes of that segment. It has bit 31 clear, bit 30 equal to the end-of-ring bit that was read, bit 29 set on the first segment of a frame, bit 28 set on the final segment, and bits [12:0] holding the number of frame bytes stored so far, CRC bytes included.
- R5: The error tag presented with the last byte maps as follows: tag bit 0 to bit 19 (CRC), tag bit 1 to bit 20 (runt), tag bit 2 to bit 22 (watchdog), tag bit 3 to bit 23 (FIFO overflow). Bit 21 is set when any status bit is set.
- R6: A frame longer than the current buffer continues in the next descriptor. The full segment is written back without the last flag only after the next descriptor has been found owned.
- R7: After a descriptor that has bit 30 set, the next descriptor is at the ring base. Otherwise it is 16 bytes further on.
- R8: If the descriptor is not owned when a frame starts, the whole frame is consumed and discarded. The missed-frame count rises by one, a descriptor-unavailable pulse is given, and the index is not advanced.
- R9: If a frame fills its buffer and the next descriptor is not owned, the filled segment is written back as last with bit 24 (buffer overflow) and bit 21 set. The rest of the frame is discarded, a descriptor-unavailable pulse is given, and the index moves to the unowned descriptor.
- R10: A one-cycle receive-OK pulse accompanies a last-segment writeback with bit 21 clear. A one-cycle receive-error pulse accompanies any writeback with bit 21 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 4 | Error tag, sampled with the final byte |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| irq_rok | output | 1 | Receive-OK pulse |
| irq_rer | output | 1 | Receive-error pulse |
| irq_rdu | output | 1 | Descriptor-unavailable pulse |
| missed | output | MISS_W | Count of frames dropped for lack of a descriptor |

## Verification
The hardest case to reach is a descriptor running out in the middle of a frame. That needs a frame longer than the owned buffers, followed by an unowned descriptor at exactly the point where a buffer fills. The stimulus arms two 16-byte descriptors, leaves the third unowned, and sends a 50-byte frame. The checks then confirm the truncated writeback, the overflow status, the discard of the tail, and that the next frame resumes at the unowned slot once it is re-armed. Another sequence drives a frame whose last byte exactly fills a buffer, to show that no look-ahead read happens then. A final frame after an end-of-ring descriptor shows the return to the ring base.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RING_BASE = 'h100,
  parameter int LEN_W = 13,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [3:0]        in_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              irq_rok,
  output logic              irq_rer,
  output logic              irq_rdu,
  output logic [MISS_W-1:0] missed
);
  localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] PTR_OFFS = ADDR_W'(8);

  typedef enum logic [2:0] {S_IDLE, S_RDC, S_RDA, S_FILL, S_PCHK, S_NXA, S_WB, S_DROP} st_t;
  st_t st;

  logic [ADDR_W-1:0] cur, buf_ptr, nxt;
  logic              cur_eor, seg_first;
  logic [LEN_W-1:0]  seg_size, seg_cnt, frame_len;
  logic [3:0]        err_q;

  wire own      = mem_rdata[31];
  wire seg_full = seg_cnt == seg_size;
  wire accept   = in_valid && in_ready;
  assign nxt      = cur_eor ? RING_BASE : cur + STRIDE;
  assign in_ready = (st == S_FILL && !seg_full) || st == S_DROP;

  function automatic logic [31:0] wb_word(input logic eor, input logic first, input logic ls,
                                          input logic bovf, input logic [3:0] err,
                                          input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[30] = eor;
    w[29] = first;
    w[28] = ls;
    w[19] = err[0];
    w[20] = err[1];
    w[22] = err[2];
    w[23] = err[3];
    w[24] = bovf;
    w[21] = bovf || (err != 4'd0);
    w[LEN_W-1:0] = len;
    return w;
  endfunction

  always_comb begin
    mem_en = 1'b0;
    mem_we = 1'b0;
    mem_addr = cur;
    mem_be = 4'h0;
    mem_wdata = '0;
    case (st)
      S_IDLE: mem_en = in_valid;
      S_RDC: begin
        mem_en = own;
        mem_addr = cur + PTR_OFFS;
      end
      S_FILL:
        if (accept) begin
          mem_en = 1'b1;
          mem_we = 1'b1;
          mem_addr = buf_ptr;
          mem_be = 4'b0001 << buf_ptr[1:0];
          mem_wdata = {4{in_data}};
        end else if (seg_full && in_valid) begin
          mem_en = 1'b1;
          mem_addr = nxt;
        end
      S_PCHK: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        mem_be = 4'hF;
        mem_wdata = own ? wb_word(cur_eor, seg_first, 1'b0, 1'b0, 4'd0, frame_len)
                        : wb_word(cur_eor, seg_first, 1'b1, 1'b1, 4'd0, frame_len);
      end
      S_NXA: begin
        mem_en = 1'b1;
        mem_addr = cur + PTR_OFFS;
      end
      S_WB: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        mem_be = 4'hF;
        mem_wdata = wb_word(cur_eor, seg_first, 1'b1, 1'b0, err_q, frame_len);
      end
      default: ;
    endcase
  end

  assign irq_rdu = (st == S_RDC || st == S_PCHK) && !own;
  assign irq_rok = st == S_WB && err_q == 4'd0;
  assign irq_rer = (st == S_WB && err_q != 4'd0) || (st == S_PCHK && !own);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= RING_BASE;
      cur_eor <= 1'b0;
      seg_first <= 1'b0;
      seg_size <= '0;
      seg_cnt <= '0;
      frame_len <= '0;
      buf_ptr <= '0;
      err_q <= '0;
      missed <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (in_valid) begin
            st <= S_RDC;
            frame_len <= '0;
            seg_first <= 1'b1;
          end
        S_RDC:
          if (own) begin
            seg_size <= mem_rdata[LEN_W-1:0];
            cur_eor <= mem_rdata[30];
            st <= S_RDA;
          end else begin
            missed <= missed + 1'b1;
            st <= S_DROP;
          end
        S_RDA: begin
          buf_ptr <= mem_rdata[ADDR_W-1:0];
          seg_cnt <= '0;
          st <= S_FILL;
        end
        S_FILL:
          if (accept) begin
            buf_ptr <= buf_ptr + 1'b1;
            seg_cnt <= seg_cnt + 1'b1;
            frame_len <= frame_len + 1'b1;
            if (in_last) begin
              err_q <= in_err;
              st <= S_WB;
            end
          end else if (seg_full && in_valid) begin
            st <= S_PCHK;
          end
        S_PCHK: begin
          cur <= nxt;
          if (own) begin
            seg_size <= mem_rdata[LEN_W-1:0];
            cur_eor <= mem_rdata[30];
            seg_first <= 1'b0;
            st <= S_NXA;
          end else begin
            st <= S_DROP;
          end
        end
        S_NXA: st <= S_RDA;
        S_WB: begin
          cur <= nxt;
          st <= S_IDLE;
        end
        S_DROP:
          if (accept && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_be != 4'hF) |-> (mem_be == (4'b0001 << mem_addr[1:0]))); // R3
  AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && st == S_FILL) |-> (seg_cnt < seg_size)); // R3
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_be == 4'hF) |-> (mem_addr[3:0] == 4'h0 && !mem_wdata[31])); // R4
  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && cur_eor) |=> (cur == RING_BASE)); // R7
  AST_MISSED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (missed != $past(missed)) |-> (missed == $past(missed) + 1'b1)); // R8
  AST_ROK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rok |-> (mem_we && mem_wdata[28] && !mem_wdata[21])); // R10
  AST_ROK_RER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rok, irq_rer})); // R10
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RING = 32'h100;
  localparam int NDESC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] in_err = '0;
  logic in_ready, mem_en, mem_we, irq_rok, irq_rer, irq_rdu;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0] mem_be;
  logic [15:0] missed;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer #(.ADDR_W(32), .RING_BASE(RING), .LEN_W(13), .MISS_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_rok(irq_rok),
    .irq_rer(irq_rer), .irq_rdu(irq_rdu), .missed(missed));

  logic [7:0] bmem [0:4095];
  logic [7:0] expb [0:4095];

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) bmem[{mem_addr[11:2], 2'(b)}] <= mem_wdata[8*b +: 8];
    end else if (mem_en) begin
      mem_rdata <= {bmem[{mem_addr[11:2], 2'd3}], bmem[{mem_addr[11:2], 2'd2}],
                    bmem[{mem_addr[11:2], 2'd1}], bmem[{mem_addr[11:2], 2'd0}]};
    end
  end

  int n_tests = 0, n_fail = 0;
  int got_rok = 0, got_rer = 0, got_rdu = 0;
  int exp_rok = 0, exp_rer = 0, exp_rdu = 0, exp_miss = 0;
  bit finished = 0;

  typedef struct { logic [31:0] addr; logic [31:0] data; string tag; } wb_t;
  wb_t wbq[$];

  bit s_own [NDESC];
  int s_size [NDESC];
  int idx = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (irq_rok) got_rok++;
    if (irq_rer) got_rer++;
    if (irq_rdu) got_rdu++;
    if (mem_en && mem_we && mem_addr >= RING && mem_addr < RING + 32'd64) begin
      if (wbq.size() == 0) check(1'b0, "R4 unexpected descriptor write", mem_wdata, 32'h0);
      else begin
        wb_t e;
        e = wbq.pop_front();
        check(mem_addr == e.addr, {e.tag, " address"}, mem_addr, e.addr);
        check(mem_wdata == e.data, e.tag, mem_wdata, e.data);
      end
    end
  end

  function automatic int dnext(int i);
    return (i == NDESC - 1) ? 0 : i + 1;
  endfunction

  function automatic logic [31:0] buf_of(int i);
    return 32'h400 + 32'(i) * 32'h100;
  endfunction

  function automatic logic [31:0] mk(int i, bit first, bit ls, logic [3:0] err, bit bovf, int len);
    logic [31:0] w = '0;
    w[30] = (i == NDESC - 1);
    w[29] = first;
    w[28] = ls;
    w[19] = err[0];
    w[20] = err[1];
    w[22] = err[2];
    w[23] = err[3];
    w[24] = bovf;
    w[21] = bovf || (err != 4'd0);
    w[12:0] = 13'(len);
    return w;
  endfunction

  task automatic put32(logic [31:0] a, logic [31:0] w);
    for (int b = 0; b < 4; b++) bmem[a[11:0] + 12'(b)] = w[8*b +: 8];
  endtask

  task automatic set_desc(int i, bit own, int size);
    logic [31:0] c = '0;
    c[31] = own;
    c[30] = (i == NDESC - 1);
    c[12:0] = 13'(size);
    put32(RING + 32'(i) * 32'd16, c);
    put32(RING + 32'(i) * 32'd16 + 32'd8, buf_of(i));
    s_own[i] = own;
    s_size[i] = size;
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 37 + k * 5 + 1) & 255);
  endfunction

  task automatic send_frame(int n, logic [3:0] err, int seed, string tag);
    int i = idx, len = 0, take;
    bit first = 1, done = 0;
    int caddr[$];
    if (!s_own[i]) begin
      exp_miss++;
      exp_rdu++;
      done = 1;
    end
    while (!done) begin
      take = (s_size[i] < n - len) ? s_size[i] : n - len;
      for (int k = 0; k < take; k++) begin
        expb[buf_of(i) + 32'(k)] = pat(seed, len + k);
        caddr.push_back(int'(buf_of(i)) + k);
      end
      len += take;
      if (len == n) begin
        wbq.push_back('{RING + 32'(i) * 32'd16, mk(i, first, 1'b1, err, 1'b0, len), tag});
        s_own[i] = 0;
        idx = dnext(i);
        if (err != 4'd0) exp_rer++; else exp_rok++;
        done = 1;
      end else if (s_own[dnext(i)]) begin
        wbq.push_back('{RING + 32'(i) * 32'd16, mk(i, first, 1'b0, 4'd0, 1'b0, len),
                        "R6 intermediate writeback"});
        s_own[i] = 0;
        i = dnext(i);
        first = 0;
      end else begin
        wbq.push_back('{RING + 32'(i) * 32'd16, mk(i, first, 1'b1, 4'd0, 1'b1, len),
                        "R9 truncated writeback"});
        s_own[i] = 0;
        idx = dnext(i);
        exp_rdu++;
        exp_rer++;
        done = 1;
      end
    end
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data = pat(seed, k);
      in_last = (k == n - 1);
      in_err = (k == n - 1) ? err : 4'd0;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    in_err = 4'd0;
    repeat (8) @(negedge clk);
    begin
      int bad = 0;
      foreach (caddr[q]) if (bmem[caddr[q]] !== expb[caddr[q]]) bad++;
      check(bad == 0, "R2 R3 buffer contents", 32'(bad), 32'd0);
    end
    check(wbq.size() == 0, "R4 missing writeback", 32'(wbq.size()), 32'd0);
    wbq.delete();
    check(got_rok == exp_rok, "R10 receive-OK pulses", 32'(got_rok), 32'(exp_rok));
    check(got_rer == exp_rer, "R10 receive-error pulses", 32'(got_rer), 32'(exp_rer));
    check(got_rdu == exp_rdu, "R8 R9 unavailable pulses", 32'(got_rdu), 32'(exp_rdu));
    check(int'(missed) == exp_miss, "R8 missed count", 32'(missed), 32'(exp_miss));
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) begin
      bmem[a] = 8'h00;
      expb[a] = 8'h00;
    end
    for (int i = 0; i < NDESC; i++) set_desc(i, 1'b1, 64);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1 ready low after reset", 32'(in_ready), 32'd0);
    check(mem_en == 1'b0, "R1 no memory request", 32'(mem_en), 32'd0);
    check(missed == 16'd0, "R1 missed count zero", 32'(missed), 32'd0);
    check({irq_rok, irq_rer, irq_rdu} == 3'b000, "R1 no interrupts", 32'({irq_rok, irq_rer, irq_rdu}), 32'd0);

    send_frame(20, 4'b0000, 1, "R4 single-segment writeback");
    send_frame(30, 4'b0001, 2, "R5 CRC status writeback");
    send_frame(100, 4'b0000, 3, "R6 final segment of spanning frame");
    send_frame(10, 4'b0000, 4, "R8 no writeback expected");

    set_desc(0, 1'b1, 16);
    set_desc(1, 1'b1, 16);
    send_frame(50, 4'b0000, 5, "R9 unused");

    set_desc(2, 1'b1, 64);
    set_desc(3, 1'b1, 64);
    send_frame(64, 4'b1010, 6, "R5 runt and overflow status on exact fill");
    send_frame(5, 4'b0100, 7, "R5 watchdog status at end of ring");
    set_desc(0, 1'b1, 64);
    send_frame(8, 4'b0000, 8, "R7 wrap to ring base");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule